// File: doc/BRIEF.md
# Factory-Restore Service Request Controller

This system-control block lets software ask the chip to return to its factory settings. Software writes a guarded service register. The write carries an unlock key and a 24-bit offset that points at a request structure in on-chip SRAM. An accepted request works through a fixed order of steps:

1. It raises a system reset event for a fixed number of cycles.
2. It checks the offset for alignment and checks that the address it forms lies inside an allowed SRAM window.
3. It fetches the first word of the structure through a simple read port.
4. It compares that word against a magic request code.

The block reports the outcome in the offset field itself. All zeros means idle or success, and all ones means failure. When the request is honoured, a single-cycle restore pulse goes to the logic that does the actual erasure.

While a request is in progress, the register ignores software writes and shows a busy flag. The offset that was written stays visible throughout, including across the internal reset event. The SRAM is external to the block. It answers a read strobe with a data-valid handshake after any latency.

Top module: `factory_req_ctrl`

## Requirements
- R1: A register write (`regWrEn`) is accepted only when bits [31:24] of `regWrData` equal 0xCA. A write with any other key leaves the register unchanged and starts nothing.
- R2: An accepted write loads bits [23:0] into the offset field. If the loaded value is 0x000000 or 0xFFFFFF, no request starts: no reset event, no memory read and no busy flag.
- R3: An accepted write with any other offset starts a request. `sysResetReq` is high for exactly 4 consecutive cycles before any memory read is issued.
- R4: `regRdData` shows the busy flag in bit 31, zeros in bits [30:24] and the offset field in bits [23:0]. While busy, every register write is ignored.
- R5: An offset whose bits [1:0] are not both zero fails. The offset field becomes 0xFFFFFF, no memory read is issued and no restore pulse occurs.
- R6: The address 0x20000000 + offset must lie within 0x20004000 to 0x2003FFF0, both ends included. Otherwise the request fails as in R5, with no memory read.
- R7: For a valid offset, `memRdEn` is high for exactly one cycle with `memAddr` equal to 0x20000000 + offset. The block then waits for `memRdValid`, however many cycles it takes.
- R8: If the returned word equals 0xFEED0001, `restoreFactory` pulses for exactly one cycle and the offset field then reads 0x000000. Any other word sets the offset field to 0xFFFFFF with no pulse.
- R9: After reset the offset field is 0x000000, busy is 0, and `sysResetReq`, `memRdEn` and `restoreFactory` are low.
- R10: The offset field keeps the written request value during the reset event and the checks, until the outcome is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Write data: key [31:24], offset [23:0] |
| regRdData | output | 32 | Read data: busy [31], offset [23:0] |
| sysResetReq | output | 1 | System reset event request |
| memAddr | output | 32 | SRAM read address |
| memRdEn | output | 1 | SRAM read strobe |
| memRdData | input | 32 | SRAM read data |
| memRdValid | input | 1 | SRAM read data valid |
| restoreFactory | output | 1 | One-cycle restore-factory action pulse |

## Verification
The bench tests both edges of the window:
- 0x4000 and 0x3FFF0 must pass.
- 0x3FFC and 0x3FFF4 must fail without a read.

A comparison that is off by one, or exclusive at an end, would either issue a read for a rejected offset or mark a good one as failed. Misaligned offsets that lie inside the window are used to catch a block that checks only the range. The reserved values 0 and 0xFFFFFF are used to catch a block that starts a reset on them. Writes during busy and writes with a wrong key are used to catch a block that lets software overwrite the offset mid-request. A random memory latency and structure words that match only at some addresses test whether the block samples the data before it is valid or samples a stale word.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W = 24;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'hCA;
  localparam logic [DATA_W-1:0] REQ_MAGIC = 32'hFEED_0001;
  localparam logic [DATA_W-1:0] SRAM_BASE = 32'h2000_0000;
  localparam logic [DATA_W-1:0] WIN_LO = 32'h2000_4000;
  localparam logic [DATA_W-1:0] WIN_HI = 32'h2003_FFF0;
  localparam int RST_CYCLES = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RESET_PULSE, S_CHECK_OFFSET, S_READ_WORD, S_WAIT_DATA, S_DONE
  } frcState_e;

  typedef struct packed {
    logic setPass;
    logic setFail;
  } frcStrobe_t;
endpackage

// File: rtl/frc_datapath.sv
module frc_datapath
  import frc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = OFF_W,
  parameter int KW = KEY_W,
  parameter logic [KW-1:0] KEY = UNLOCK_KEY,
  parameter logic [DW-1:0] MAGIC = REQ_MAGIC,
  parameter logic [DW-1:0] BASE = SRAM_BASE,
  parameter logic [DW-1:0] LO = WIN_LO,
  parameter logic [DW-1:0] HI = WIN_HI
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  input  logic          busy,
  input  frcStrobe_t    ctl,
  input  logic          memRdEn,
  input  logic [DW-1:0] memRdData,
  output logic [DW-1:0] regRdData,
  output logic [DW-1:0] memAddr,
  output logic          startReq,
  output logic          offsetOk,
  output logic          wordMatch
);
  localparam logic [OW-1:0] OFF_ZERO = '0;
  localparam logic [OW-1:0] OFF_ONES = '1;
  localparam int PAD_W = DW - OW - 1;

  logic [OW-1:0] offsetQ;
  logic [OW-1:0] wrOffset;
  logic [KW-1:0] wrKey;
  logic          acceptWr;

  assign wrKey    = regWrData[DW-1 -: KW];
  assign wrOffset = regWrData[OW-1:0];
  assign acceptWr = regWrEn && (wrKey == KEY) && !busy;
  assign startReq = acceptWr && (wrOffset != OFF_ZERO) && (wrOffset != OFF_ONES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= OFF_ZERO;
    end else if (ctl.setFail) begin
      offsetQ <= OFF_ONES;
    end else if (ctl.setPass) begin
      offsetQ <= OFF_ZERO;
    end else if (acceptWr) begin
      offsetQ <= wrOffset;
    end
  end

  assign memAddr   = BASE + {{(DW-OW){1'b0}}, offsetQ};
  assign offsetOk  = (offsetQ[1:0] == 2'b00) && (memAddr >= LO) && (memAddr <= HI);
  assign wordMatch = (memRdData == MAGIC);
  assign regRdData = {busy, {PAD_W{1'b0}}, offsetQ};

  AST_NO_BAD_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> offsetOk) else $error("read issued for invalid offset"); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.setPass && !ctl.setFail) |=> $stable(offsetQ)) else $error("offset changed while busy"); // R4
  AST_PASS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setPass |=> (offsetQ == OFF_ZERO)) else $error("offset not cleared"); // R8
endmodule

// File: rtl/frc_ctrl.sv
module frc_ctrl
  import frc_pkg::*;
#(
  parameter int RST_LEN = RST_CYCLES
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       offsetOk,
  input  logic       wordMatch,
  input  logic       memRdValid,
  output frcStrobe_t ctl,
  output logic       busy,
  output logic       sysResetReq,
  output logic       memRdEn,
  output logic       restoreFactory
);
  localparam int CNT_W = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_LEN - 1);

  frcState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ;
  logic passQ, passD;

  always_comb begin
    stateD = stateQ;
    passD  = passQ;
    unique case (stateQ)
      S_IDLE:         if (startReq) stateD = S_RESET_PULSE;
      S_RESET_PULSE:  if (cntQ == CNT_LAST) stateD = S_CHECK_OFFSET;
      S_CHECK_OFFSET: begin
        passD  = 1'b0;
        stateD = offsetOk ? S_READ_WORD : S_DONE;
      end
      S_READ_WORD:    stateD = S_WAIT_DATA;
      S_WAIT_DATA:    if (memRdValid) begin
        passD  = wordMatch;
        stateD = S_DONE;
      end
      S_DONE:         stateD = S_IDLE;
      default:        stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
      passQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      passQ  <= passD;
      if (stateQ == S_RESET_PULSE) cntQ <= cntQ + 1'b1;
      else cntQ <= '0;
    end
  end

  assign busy           = (stateQ != S_IDLE);
  assign sysResetReq    = (stateQ == S_RESET_PULSE);
  assign memRdEn        = (stateQ == S_READ_WORD);
  assign restoreFactory = (stateQ == S_DONE) && passQ;
  assign ctl.setPass    = (stateQ == S_DONE) && passQ;
  assign ctl.setFail    = (stateQ == S_DONE) && !passQ;

  AST_RESET_BEFORE_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_CHECK_OFFSET) |-> $past(sysResetReq)) else $error("check without reset event"); // R3
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn) else $error("read strobe longer than one cycle"); // R7
  AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    restoreFactory |=> !restoreFactory) else $error("restore pulse too long"); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(sysResetReq || memRdEn || restoreFactory)) else $error("activity while idle"); // R2
endmodule

// File: rtl/factory_req_ctrl.sv
module factory_req_ctrl
  import frc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sysResetReq,
  output logic [DATA_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memRdValid,
  output logic              restoreFactory
);
  frcStrobe_t ctl;
  logic busy, startReq, offsetOk, wordMatch;

  frc_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .busy(busy), .ctl(ctl), .memRdEn(memRdEn), .memRdData(memRdData),
    .regRdData(regRdData), .memAddr(memAddr), .startReq(startReq),
    .offsetOk(offsetOk), .wordMatch(wordMatch)
  );

  frc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .offsetOk(offsetOk),
    .wordMatch(wordMatch), .memRdValid(memRdValid), .ctl(ctl), .busy(busy),
    .sysResetReq(sysResetReq), .memRdEn(memRdEn), .restoreFactory(restoreFactory)
  );
endmodule

// File: tb/factory_req_ctrl_test.sv
module factory_req_ctrl_test;
  logic clk = 0, rstN = 0;
  logic regWrEn = 0;
  logic [31:0] regWrData = 0, regRdData, memAddr, memRdData = 0;
  logic sysResetReq, memRdEn, restoreFactory, memRdValid = 0;
  int nTests = 0, nFail = 0;
  int rstCnt = 0, rstRun = 0, rstMaxRun = 0, rdCnt = 0, restCnt = 0, restRun = 0, restMaxRun = 0;
  int rdBeforeRst = 0;
  logic [31:0] lastAddr = 0;
  int memDelay = -1;
  logic [31:0] pendAddr = 0;

  factory_req_ctrl uut (.*);

  always #5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  function automatic logic [31:0] memWord(logic [31:0] a);
    return a[2] ? (a ^ 32'h5A5A_0000) : 32'hFEED_0001;
  endfunction

  function automatic bit offValid(logic [23:0] o);
    logic [31:0] a = 32'h2000_0000 + {8'h0, o};
    return (o[1:0] == 0) && (a >= 32'h2000_4000) && (a <= 32'h2003_FFF0);
  endfunction

  always @(negedge clk) begin
    if (sysResetReq) begin rstCnt++; rstRun++; if (rstRun > rstMaxRun) rstMaxRun = rstRun; end
    else rstRun = 0;
    if (restoreFactory) begin restCnt++; restRun++; if (restRun > restMaxRun) restMaxRun = restRun; end
    else restRun = 0;
    memRdValid <= 0;
    if (memDelay == 0) begin memRdValid <= 1; memRdData <= memWord(pendAddr); memDelay = -1; end
    else if (memDelay > 0) begin memDelay--; memRdData <= $urandom; end
    if (memRdEn) begin
      rdCnt++; lastAddr = memAddr; pendAddr = memAddr; memDelay = $urandom_range(3, 0);
      if (rstCnt == 0) rdBeforeRst++;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (!ok) begin nFail++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic writeReg(logic [7:0] key, logic [23:0] off);
    @(negedge clk); regWrEn = 1; regWrData = {key, off};
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic clearCounters();
    rstCnt = 0; rstMaxRun = 0; rdCnt = 0; restCnt = 0; restMaxRun = 0; rdBeforeRst = 0;
  endtask

  task automatic waitIdle();
    int g = 0;
    while (regRdData[31] && g < 200) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  // full request with expected outcome from bench model
  task automatic request(logic [23:0] off);
    bit valid = offValid(off);
    logic [31:0] a = 32'h2000_0000 + {8'h0, off};
    bit pass = valid && (memWord(a) == 32'hFEED_0001);
    clearCounters();
    writeReg(8'hCA, off);
    check(regRdData[31] == 1, "R3 busy after start", regRdData, 32'h8000_0000);
    check(regRdData[23:0] == off, "R10 offset held during reset", {8'h0, regRdData[23:0]}, {8'h0, off});
    writeReg(8'hCA, 24'h00_4000 ^ off);
    check(regRdData[23:0] == off, "R4 write while busy ignored", {8'h0, regRdData[23:0]}, {8'h0, off});
    waitIdle();
    check(rstCnt == 4 && rstMaxRun == 4 && rdBeforeRst == 0, "R3 reset event length", rstCnt, 4);
    check(rdCnt == (valid ? 1 : 0), valid ? "R7 one read" : "R5/R6 no read", rdCnt, valid);
    if (valid) check(lastAddr == a, "R7 read address", lastAddr, a);
    check(restCnt == (pass ? 1 : 0) && restMaxRun <= 1, "R8 restore pulse", restCnt, pass);
    check(regRdData == (pass ? 32'h0 : 32'h00FF_FFFF), "R8 outcome in offset", regRdData,
          pass ? 32'h0 : 32'h00FF_FFFF);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(regRdData == 0 && !sysResetReq && !memRdEn && !restoreFactory, "R9 reset state", regRdData, 0);

    // R1 wrong key
    clearCounters();
    writeReg(8'hCB, 24'h00_4000);
    repeat (3) @(negedge clk);
    check(regRdData == 0 && rstCnt == 0, "R1 bad key ignored", regRdData, 0);
    // R2 reserved values
    writeReg(8'hCA, 24'hFF_FFFF);
    repeat (3) @(negedge clk);
    check(regRdData == 32'h00FF_FFFF && rstCnt == 0, "R2 all-ones no request", regRdData, 32'h00FF_FFFF);
    writeReg(8'hCA, 24'h00_0000);
    repeat (3) @(negedge clk);
    check(regRdData == 0 && rstCnt == 0 && rdCnt == 0, "R2 zero no request", regRdData, 0);

    // directed boundaries
    request(24'h00_4000);  // R6 low edge, pass
    request(24'h03_FFF0);  // R6 high edge, pass
    request(24'h00_3FFC);  // R6 below
    request(24'h03_FFF4);  // R6 above
    request(24'h00_4002);  // R5 misaligned
    request(24'h00_4001);  // R5 misaligned
    request(24'h00_4004);  // R8 wrong word

    for (int i = 0; i < 60; i++) begin
      logic [23:0] off;
      if (i % 2 == 0) off = 24'(32'h4000 + ($urandom % 32'hEFFD) * 4);
      else off = 24'($urandom);
      if (off == 24'h0 || off == 24'hFF_FFFF) off = 24'h00_4008;
      request(off);
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule